// File: doc/BRIEF.md
# Page Address Translator with Untranslated Fallback

This block converts the addresses carried by DMA commands from a virtual space into a physical space. It works one page at a time. It keeps a small fully associative table, and each entry pairs a virtual page number with a physical page number. A separate management port adds, rewrites and deletes entries one request per cycle. The lookup port takes one address at a time over a valid/ready handshake. After a fixed overhead that is set by a parameter, it returns the physical address.

When an address matches no entry, this is not treated as a fault. The address goes out unchanged and is treated as physical, so traffic that only ever uses raw physical addresses still works. A per-request bypass input forces the same untranslated result. It serves resources that sit at fixed addresses. The page size, the address width, the table depth and the overhead are all parameters.

Top module: `xlt_page_translator`

## Requirements
- R1: After reset, `rsp_valid`, `map_done` and `map_err` are 0 and `req_ready` is 1. No page is mapped after reset.
- R2: When the page number of an address matches a valid entry, the response has `rsp_hit`=1. Its upper bits `[ADDR_W-1:OFF_W]` hold the entry's physical page number, and its low `OFF_W` bits (OFF_W = log2 PAGE_BYTES) equal the request's low bits.
- R3: When an address matches no valid entry, the response has `rsp_hit`=0 and `rsp_paddr` equals `req_addr`.
- R4: A request with `req_bypass`=1 returns `req_addr` unchanged with `rsp_hit`=0, even when its page is mapped.
- R5: `rsp_valid` rises LAT+1 cycles after the cycle in which a request is accepted. With LAT=0 this is the following cycle.
- R6: A management request with `map_op`=0 installs `map_vpage`→`map_ppage`. `map_done` pulses for one cycle in the next cycle. Any lookup accepted after that uses the new entry.
- R7: Installing a virtual page that is already mapped replaces its physical page. It does not use a second entry and does not raise `map_err`.
- R8: A request with `map_op`=1 removes the entry for `map_vpage`, and later lookups of that page pass through. Removing a page that is not mapped still pulses `map_done`, with `map_err`=0.
- R9: An install of a new page while all ENTRIES entries are valid is rejected. `map_done` and `map_err` are both 1, the table is unchanged, and the rejected page stays untranslated.
- R10: `req_ready` is 0 from the accepting edge until the response has been taken with `rsp_ready`=1. While `rsp_valid`=1 and `rsp_ready`=0, the response holds steady.
- R11: A removal frees its entry, so a later install of a new page succeeds in a table that was full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| map_valid | input | 1 | Management request strobe |
| map_op | input | 1 | 0 = install, 1 = remove |
| map_vpage | input | ADDR_W-OFF_W | Virtual page number |
| map_ppage | input | ADDR_W-OFF_W | Physical page number (install only) |
| map_done | output | 1 | Request completed (one-cycle pulse) |
| map_err | output | 1 | Install rejected: table full |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_addr | input | ADDR_W | Address to translate |
| req_bypass | input | 1 | Force untranslated result |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumed |
| rsp_paddr | output | ADDR_W | Physical address |
| rsp_hit | output | 1 | 1 when a table entry was applied |

## Verification
A table entry that is stuck or stale shows up on the next response for that page. `rsp_hit` then has the wrong value, or `rsp_paddr` carries the wrong upper bits. This appears LAT+1 cycles after the lookup is accepted. A wrong count of free entries shows up at a management request: `map_err` is wrong in the cycle after an install, once the table is close to full. A fault in the latency counter or in the handshake state appears as a `rsp_valid` edge at the wrong time, or as `req_ready` being 1 while a response is still outstanding. Both are visible within the window of a single request.

// File: rtl/xlt_pkg.sv
`timescale 1ns/1ps
package xlt_pkg;

    localparam int unsigned DEF_ADDR_W     = 40;
    localparam int unsigned DEF_PAGE_BYTES = 4096;
    localparam int unsigned DEF_ENTRIES    = 16;
    localparam int unsigned DEF_LAT        = 2;

    typedef enum logic {
        OP_INSTALL = 1'b0,
        OP_REMOVE  = 1'b1
    } map_op_e;

    // width of a counter that must hold the value n (at least one bit)
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/xlt_table.sv
`timescale 1ns/1ps
module xlt_table
    import xlt_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned PN_W    = 28
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            map_valid,
    input  map_op_e         map_op,
    input  logic [PN_W-1:0] map_vpage,
    input  logic [PN_W-1:0] map_ppage,
    output logic            map_done,
    output logic            map_err,
    input  logic [PN_W-1:0] lk_vpage,
    output logic            lk_hit,
    output logic [PN_W-1:0] lk_ppage
);
    localparam int unsigned IDX_W = cnt_width(ENTRIES - 1);

    logic [ENTRIES-1:0] ent_valid;
    logic [PN_W-1:0]    ent_vpn [ENTRIES];
    logic [PN_W-1:0]    ent_ppn [ENTRIES];
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] mp_match;
    logic               free_found;
    logic [IDX_W-1:0]   free_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g] = ent_valid[g] && (ent_vpn[g] == lk_vpage);
        assign mp_match[g] = ent_valid[g] && (ent_vpn[g] == map_vpage);
    end

    assign lk_hit = |lk_match;

    // at most one entry matches, so OR-ing the masked numbers selects it
    always_comb begin
        lk_ppage = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) lk_ppage = lk_ppage | ent_ppn[i];
        end
    end

    // lowest-numbered free entry
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid <= '0;
            map_done  <= 1'b0;
            map_err   <= 1'b0;
        end else begin
            map_done <= map_valid;
            map_err  <= 1'b0;
            if (map_valid) begin
                if (map_op == OP_REMOVE) begin
                    ent_valid <= ent_valid & ~mp_match;
                end else if (|mp_match) begin
                    for (int i = 0; i < ENTRIES; i++) begin
                        if (mp_match[i]) ent_ppn[i] <= map_ppage;
                    end
                end else if (free_found) begin
                    ent_valid[free_idx] <= 1'b1;
                    ent_vpn[free_idx]   <= map_vpage;
                    ent_ppn[free_idx]   <= map_ppage;
                end else begin
                    map_err <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/xlt_resp_pipe.sv
`timescale 1ns/1ps
module xlt_resp_pipe
    import xlt_pkg::*;
#(
    parameter int unsigned W   = DEF_ADDR_W,
    parameter int unsigned LAT = DEF_LAT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_addr,
    input  logic         in_hit,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_addr,
    output logic         out_hit
);
    localparam int unsigned CW = cnt_width(LAT);

    logic         vld_q;
    logic [W-1:0] addr_q;
    logic         hit_q;

    assign out_valid = vld_q;
    assign out_addr  = addr_q;
    assign out_hit   = hit_q;

    if (LAT == 0) begin : g_direct
        assign in_ready = !vld_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q  <= 1'b0;
                addr_q <= '0;
                hit_q  <= 1'b0;
            end else if (in_valid && in_ready) begin
                vld_q  <= 1'b1;
                addr_q <= in_addr;
                hit_q  <= in_hit;
            end else if (vld_q && out_ready) begin
                vld_q <= 1'b0;
            end
        end
    end else begin : g_count
        logic          pend_q;
        logic [CW-1:0] cnt_q;

        assign in_ready = !vld_q && !pend_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q  <= 1'b0;
                pend_q <= 1'b0;
                cnt_q  <= '0;
                addr_q <= '0;
                hit_q  <= 1'b0;
            end else if (in_valid && in_ready) begin
                pend_q <= 1'b1;
                cnt_q  <= CW'(LAT);
                addr_q <= in_addr;
                hit_q  <= in_hit;
            end else if (pend_q) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    pend_q <= 1'b0;
                    vld_q  <= 1'b1;
                end
            end else if (vld_q && out_ready) begin
                vld_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/xlt_page_translator.sv
`timescale 1ns/1ps
module xlt_page_translator
    import xlt_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned PAGE_BYTES = DEF_PAGE_BYTES,
    parameter int unsigned ENTRIES    = DEF_ENTRIES,
    parameter int unsigned LAT        = DEF_LAT,
    localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
    localparam int unsigned PN_W      = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              map_valid,
    input  logic              map_op,
    input  logic [PN_W-1:0]   map_vpage,
    input  logic [PN_W-1:0]   map_ppage,
    output logic              map_done,
    output logic              map_err,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_bypass,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_hit
);
    logic              lk_hit;
    logic [PN_W-1:0]   lk_ppage;
    logic              use_xlt;
    logic [ADDR_W-1:0] xaddr;

    xlt_table #(
        .ENTRIES (ENTRIES),
        .PN_W    (PN_W)
    ) u_table (
        .clk       (clk),
        .rst       (rst),
        .map_valid (map_valid),
        .map_op    (map_op_e'(map_op)),
        .map_vpage (map_vpage),
        .map_ppage (map_ppage),
        .map_done  (map_done),
        .map_err   (map_err),
        .lk_vpage  (req_addr[ADDR_W-1:OFF_W]),
        .lk_hit    (lk_hit),
        .lk_ppage  (lk_ppage)
    );

    assign use_xlt = lk_hit && !req_bypass;
    assign xaddr   = use_xlt ? {lk_ppage, req_addr[OFF_W-1:0]} : req_addr;

    xlt_resp_pipe #(
        .W   (ADDR_W),
        .LAT (LAT)
    ) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_addr   (xaddr),
        .in_hit    (use_xlt),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .out_addr  (rsp_paddr),
        .out_hit   (rsp_hit)
    );

endmodule

// File: rtl/xlt_chk.sv
`timescale 1ns/1ps
module xlt_chk #(
    parameter int unsigned ADDR_W = 40,
    parameter int unsigned OFF_W  = 12,
    parameter int unsigned LAT    = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              map_valid,
    input logic              map_op,
    input logic              map_done,
    input logic              map_err,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_bypass,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic              rsp_hit
);
    logic [ADDR_W-1:0] acc_addr_q;
    logic              acc_byp_q;
    logic [15:0]       wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_addr_q <= '0;
            acc_byp_q  <= 1'b0;
            wait_q     <= '0;
        end else if (req_valid && req_ready) begin
            acc_addr_q <= req_addr;
            acc_byp_q  <= req_bypass;
            wait_q     <= '0;
        end else if (!rsp_valid && wait_q != 16'hFFFF) begin
            wait_q <= wait_q + 16'd1;
        end
    end

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_hit));

    // R10
    busy_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_valid) |-> wait_q == 16'(LAT));

    // R3
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_hit |-> rsp_paddr == acc_addr_q);

    // R4
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && acc_byp_q |-> !rsp_hit);

    // R2
    offset_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_paddr[OFF_W-1:0] == acc_addr_q[OFF_W-1:0]);

    // R9
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        map_err |-> map_done && $past(map_valid && !map_op));

endmodule

bind xlt_page_translator xlt_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .LAT    (LAT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .map_valid  (map_valid),
    .map_op     (map_op),
    .map_done   (map_done),
    .map_err    (map_err),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_bypass (req_bypass),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_paddr  (rsp_paddr),
    .rsp_hit    (rsp_hit)
);

// File: tb/xlt_page_translator_tb.sv
`timescale 1ns/1ps
module xlt_page_translator_tb;
    localparam int AW  = 40;
    localparam int PW  = 28;
    localparam int LAT = 2;
    localparam int NV  = 6;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          byp;
        logic [AW-1:0] exp_pa;
        logic          exp_hit;
    } vec_t;

    // installed before the walk: 0x10->0xA00, 0x11->0xB07, 0x12345->0x1
    localparam vec_t VECS [NV] = '{
        '{{28'h10, 12'h234},      1'b0, {28'hA00, 12'h234},  1'b1},  // R2
        '{{28'h11, 12'hFFF},      1'b0, {28'hB07, 12'hFFF},  1'b1},  // R2
        '{{28'h12345, 12'h000},   1'b0, {28'h1, 12'h000},    1'b1},  // R2
        '{{28'h20, 12'h5A5},      1'b0, {28'h20, 12'h5A5},   1'b0},  // R3
        '{{28'h10, 12'h001},      1'b1, {28'h10, 12'h001},   1'b0},  // R4
        '{{28'hFFFFFFF, 12'hABC}, 1'b0, {28'hFFFFFFF, 12'hABC}, 1'b0} // R3
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          map_valid, map_op;
    logic [PW-1:0] map_vpage, map_ppage;
    logic          map_done, map_err;
    logic          req_valid, req_ready, req_bypass;
    logic [AW-1:0] req_addr;
    logic          rsp_valid, rsp_ready, rsp_hit;
    logic [AW-1:0] rsp_paddr;

    int  tests = 0;
    int  fails = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    xlt_page_translator #(.ADDR_W(AW), .PAGE_BYTES(4096), .ENTRIES(16), .LAT(LAT)) u_dut (
        .clk(clk), .rst(rst),
        .map_valid(map_valid), .map_op(map_op), .map_vpage(map_vpage), .map_ppage(map_ppage),
        .map_done(map_done), .map_err(map_err),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_bypass(req_bypass),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_map(input logic op, input logic [PW-1:0] v, input logic [PW-1:0] p,
                          output logic done, output logic err);
        @(negedge clk);
        map_valid = 1'b1; map_op = op; map_vpage = v; map_ppage = p;
        @(posedge clk);
        @(negedge clk);
        done = map_done; err = map_err;
        map_valid = 1'b0;
    endtask

    task automatic lookup(input logic [AW-1:0] a, input logic byp, input int stall,
                          output logic [AW-1:0] pa, output logic hit, output int lat);
        @(negedge clk);
        req_addr = a; req_bypass = byp; req_valid = 1'b1;
        check(req_ready == 1'b1, "R10 ready before request", 64'(req_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 50) begin
            check(req_ready == 1'b0, "R10 ready while pending", 64'(req_ready), 64'd0);
            @(negedge clk);
            lat++;
        end
        pa = rsp_paddr; hit = rsp_hit;
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check(rsp_valid && rsp_paddr == pa && rsp_hit == hit && !req_ready,
                  "R10 held under stall", 64'(rsp_paddr), 64'(pa));
        end
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 1'b0;
        check(!rsp_valid && req_ready, "R10 released after take", 64'(rsp_valid), 64'd0);
    endtask

    task automatic expect_lookup(input logic [AW-1:0] a, input logic byp,
                                 input logic [AW-1:0] exp_pa, input logic exp_hit, input string req);
        logic [AW-1:0] pa;
        logic          hit;
        int            lat;
        lookup(a, byp, 0, pa, hit, lat);
        check(pa == exp_pa, req, 64'(pa), 64'(exp_pa));
        check(hit == exp_hit, req, 64'(hit), 64'(exp_hit));
        check(lat == LAT + 1, "R5 latency", 64'(lat), 64'(LAT + 1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 64'd0, 64'd1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic          d, e;
        logic [AW-1:0] pa;
        logic          hit;
        int            lat;

        rst = 1'b1;
        map_valid = 1'b0; map_op = 1'b0; map_vpage = '0; map_ppage = '0;
        req_valid = 1'b0; req_addr = '0; req_bypass = 1'b0; rsp_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(!rsp_valid && req_ready && !map_done && !map_err, "R1 reset outputs",
              {60'd0, rsp_valid, req_ready, map_done, map_err}, 64'b0100);
        expect_lookup({28'h10, 12'h234}, 1'b0, {28'h10, 12'h234}, 1'b0, "R1 empty table passthrough");

        // R6 installs
        do_map(1'b0, 28'h10, 28'hA00, d, e);
        check(d && !e, "R6 install done", {62'd0, d, e}, 64'b10);
        do_map(1'b0, 28'h11, 28'hB07, d, e);
        do_map(1'b0, 28'h12345, 28'h1, d, e);
        check(d && !e, "R6 install done", {62'd0, d, e}, 64'b10);
        @(negedge clk);
        check(!map_done, "R6 done is a pulse", 64'(map_done), 64'd0);

        for (int i = 0; i < NV; i++) begin
            expect_lookup(VECS[i].addr, VECS[i].byp, VECS[i].exp_pa, VECS[i].exp_hit,
                          $sformatf("R2/R3/R4 vector %0d", i));
        end

        // R7 overwrite
        do_map(1'b0, 28'h10, 28'h777, d, e);
        check(d && !e, "R7 overwrite accepted", {62'd0, d, e}, 64'b10);
        expect_lookup({28'h10, 12'h0C0}, 1'b0, {28'h777, 12'h0C0}, 1'b1, "R7 new mapping used");

        // R8 removal
        do_map(1'b1, 28'h10, 28'h0, d, e);
        check(d && !e, "R8 remove done", {62'd0, d, e}, 64'b10);
        expect_lookup({28'h10, 12'h0C0}, 1'b0, {28'h10, 12'h0C0}, 1'b0, "R8 removed page passes through");
        do_map(1'b1, 28'h99, 28'h0, d, e);
        check(d && !e, "R8 absent remove no error", {62'd0, d, e}, 64'b10);

        // R9 fill the table (two entries in use), then overflow
        for (int i = 0; i < 14; i++) begin
            do_map(1'b0, 28'h100 + 28'(i), 28'h5000 + 28'(i), d, e);
            check(d && !e, "R9 fill accepted", {62'd0, d, e}, 64'b10);
        end
        do_map(1'b0, 28'h200, 28'h6000, d, e);
        check(d && e, "R9 full table rejects", {62'd0, d, e}, 64'b11);
        expect_lookup({28'h200, 12'h010}, 1'b0, {28'h200, 12'h010}, 1'b0, "R9 rejected page passthrough");
        expect_lookup({28'h11, 12'h010}, 1'b0, {28'hB07, 12'h010}, 1'b1, "R9 old entry intact");
        expect_lookup({28'h10D, 12'h3}, 1'b0, {28'h500D, 12'h3}, 1'b1, "R9 last fill entry");
        do_map(1'b0, 28'h11, 28'hB08, d, e);
        check(d && !e, "R7 overwrite while full", {62'd0, d, e}, 64'b10);

        // R11 free an entry and reuse it
        do_map(1'b1, 28'h100, 28'h0, d, e);
        do_map(1'b0, 28'h200, 28'h6000, d, e);
        check(d && !e, "R11 install after free", {62'd0, d, e}, 64'b10);
        expect_lookup({28'h200, 12'h010}, 1'b0, {28'h6000, 12'h010}, 1'b1, "R11 reused entry");

        // R10 stall with response held
        lookup({28'h12345, 12'h777}, 1'b0, 4, pa, hit, lat);
        check(pa == {28'h1, 12'h777} && hit, "R10 stalled result", 64'(pa), 64'({28'h1, 12'h777}));

        // R1 reset clears the table
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        expect_lookup({28'h11, 12'h010}, 1'b0, {28'h11, 12'h010}, 1'b0, "R1 table cleared by reset");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule